// File: doc/BRIEF.md
# Shared Memory Bank Conflict Arbiter

This block schedules the shared-memory accesses of one half-warp, sixteen threads by default. The caller presents, for each thread, an active flag and a word address, then pulses a start input. The block finds the bank of each address, which is the address modulo the bank count. It then splits the pending requests into rounds so that no bank sees two different addresses in the same round. Threads that ask for exactly the same word are served together as a broadcast, so only true conflicts add rounds.

During each round the block drives a per-thread grant mask. It also drives a per-bank enable and the word address each bank must serve. Done rises in the final round of the operation. Once a request is loaded, the round count is the largest number of distinct addresses that fall into any one bank. The block is the scheduling stage that sits next to the bank arrays. It stores no data and routes none.

Top module: `smem_bank_arbiter`

## Requirements
- R1: The bank of a word address is its low log2(BANKS) bits (address modulo BANKS). In every round, a granted thread's bank has bank_en_o set, and that bank's slot of bank_addr_o (bits b*AW upward) holds the thread's full address.
- R2: In any round each bank serves at most one distinct address. Every thread granted in that bank has exactly the address in the bank's slot.
- R3: In every round, for every bank that still has pending threads, the lowest-numbered pending thread of that bank is granted. A bank with no pending thread has bank_en_o low.
- R4: A pending thread whose address equals the address of any thread granted in the same round is granted in that round (broadcast). Sixteen active threads on one address complete in one round with all grant bits set.
- R5: The number of rounds equals the largest count of distinct active addresses in any single bank, and at least one. done_o is high in the last round and only there, and busy_o falls in the cycle after done_o.
- R6: Over one operation, every active thread is granted exactly once.
- R7: Inactive threads are never granted and do not change the number of rounds.
- R8: A start with no active thread gives one round with an all-zero grant mask and done_o high.
- R9: A start seen while idle loads the request, and busy_o is high in the next cycle. A start seen while busy is ignored, and the running operation keeps its round count and grants.
- R10: During and right after reset, busy_o, done_o, grant_o and bank_en_o are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Load the presented request when idle |
| req_active_i | input | THREADS | Per-thread active flag |
| req_addr_i | input | THREADS*AW | Per-thread word address, thread t at bits t*AW upward |
| busy_o | output | 1 | An operation is in progress, one round per cycle |
| done_o | output | 1 | The current round is the last one |
| grant_o | output | THREADS | Threads served in the current round |
| bank_en_o | output | BANKS | Banks accessed in the current round |
| bank_addr_o | output | BANKS*AW | Word address served by each bank, bank b at bits b*AW upward |

## Verification
The bench builds the block with THREADS=16, BANKS=16 and AW=8. This leaves four address bits above the bank index, so sixteen different addresses can land in one bank. That brings the deepest case, sixteen rounds, within reach alongside single-round distinct-bank and broadcast patterns. With sixteen threads and sixteen banks, the lowest-thread priority, broadcast merging, inactive-thread masking and the start-while-busy case can all be checked round by round against a round count the bench works out from the addresses alone.

// File: rtl/sba_pkg.sv
package sba_pkg;

   typedef enum logic {
      SBA_IDLE  = 1'b0,
      SBA_SERVE = 1'b1
   } sba_state_t;

   function automatic bit sba_is_pow2(input int n);
      return (n > 0) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/sba_bank_pick.sv
module sba_bank_pick #(
   parameter int THREADS = 16,
   parameter int AW      = 10,
   parameter int BW      = 4,
   parameter int BANK_ID = 0
) (
   input  logic [THREADS-1:0]    pend_i,
   input  logic [THREADS*AW-1:0] addr_i,
   output logic                  en_o,
   output logic [AW-1:0]         addr_o
);
   localparam logic [BW-1:0] MY_BANK = BW'(BANK_ID);

   logic [THREADS-1:0] hit;

   for (genvar t = 0; t < THREADS; t++) begin : g_hit
      assign hit[t] = pend_i[t] && (addr_i[t*AW +: BW] == MY_BANK);
   end

   // lowest-numbered hitting thread owns the bank this round
   always_comb begin
      en_o   = 1'b0;
      addr_o = '0;
      for (int t = THREADS - 1; t >= 0; t--) begin
         if (hit[t]) begin
            en_o   = 1'b1;
            addr_o = addr_i[t*AW +: AW];
         end
      end
   end

   // R1
   bank_match_chk: assert property (@(addr_o) en_o |-> (addr_o[BW-1:0] == MY_BANK))
      else $error("bank slot holds address of another bank");

endmodule

// File: rtl/sba_grant_match.sv
module sba_grant_match #(
   parameter int THREADS = 16,
   parameter int BANKS   = 16,
   parameter int AW      = 10,
   parameter int BW      = 4
) (
   input  logic [THREADS-1:0]    pend_i,
   input  logic [THREADS*AW-1:0] addr_i,
   input  logic [BANKS-1:0]      bank_en_i,
   input  logic [BANKS*AW-1:0]   bank_addr_i,
   output logic [THREADS-1:0]    grant_o
);
   for (genvar t = 0; t < THREADS; t++) begin : g_thr
      logic [BW-1:0] bsel;
      logic [AW-1:0] mine;
      logic [AW-1:0] served;
      assign bsel   = addr_i[t*AW +: BW];
      assign mine   = addr_i[t*AW +: AW];
      assign served = bank_addr_i[int'(bsel)*AW +: AW];
      // same word as the bank's chosen address -> broadcast grant
      assign grant_o[t] = pend_i[t] && bank_en_i[bsel] && (mine == served);
   end
endmodule

// File: rtl/smem_bank_arbiter.sv
module smem_bank_arbiter
   import sba_pkg::*;
#(
   parameter int THREADS = 16,
   parameter int BANKS   = 16,
   parameter int AW      = 10
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start_i,
   input  logic [THREADS-1:0]    req_active_i,
   input  logic [THREADS*AW-1:0] req_addr_i,
   output logic                  busy_o,
   output logic                  done_o,
   output logic [THREADS-1:0]    grant_o,
   output logic [BANKS-1:0]      bank_en_o,
   output logic [BANKS*AW-1:0]   bank_addr_o
);
   localparam int BW = $clog2(BANKS);

   if (!sba_is_pow2(BANKS) || BANKS < 2) begin : g_bad_banks
      $error("BANKS must be a power of two, at least 2");
   end
   if (AW < BW) begin : g_bad_aw
      $error("AW must cover the bank index");
   end
   if (THREADS < 1) begin : g_bad_thr
      $error("THREADS must be positive");
   end

   sba_state_t            state_q;
   logic [THREADS-1:0]    pend_q;
   logic [THREADS*AW-1:0] addr_q;
   logic [THREADS-1:0]    grant;
   logic                  last_round;

   for (genvar b = 0; b < BANKS; b++) begin : g_bank
      sba_bank_pick #(
         .THREADS (THREADS),
         .AW      (AW),
         .BW      (BW),
         .BANK_ID (b)
      ) u_pick (
         .pend_i (pend_q),
         .addr_i (addr_q),
         .en_o   (bank_en_o[b]),
         .addr_o (bank_addr_o[b*AW +: AW])
      );
   end

   sba_grant_match #(
      .THREADS (THREADS),
      .BANKS   (BANKS),
      .AW      (AW),
      .BW      (BW)
   ) u_match (
      .pend_i      (pend_q),
      .addr_i      (addr_q),
      .bank_en_i   (bank_en_o),
      .bank_addr_i (bank_addr_o),
      .grant_o     (grant)
   );

   assign busy_o     = (state_q == SBA_SERVE);
   assign last_round = busy_o && ((pend_q & ~grant) == '0);
   assign done_o     = last_round;
   assign grant_o    = grant;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SBA_IDLE;
         pend_q  <= '0;
         addr_q  <= '0;
      end else begin
         unique case (state_q)
            SBA_IDLE: begin
               if (start_i) begin
                  pend_q  <= req_active_i;
                  addr_q  <= req_addr_i;
                  state_q <= SBA_SERVE;
               end
            end
            SBA_SERVE: begin
               pend_q <= pend_q & ~grant;
               if (last_round) state_q <= SBA_IDLE;
            end
            default: state_q <= SBA_IDLE;
         endcase
      end
   end

   // R7
   grant_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_o & ~pend_q) == '0)
      else $error("grant to a thread that is not pending");

   // R3
   progress_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && (pend_q != '0)) |-> (grant_o != '0))
      else $error("round with pending work granted nothing");

   // R5
   done_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !busy_o)
      else $error("busy after last round");

   // R5
   keep_going_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !done_o) |=> busy_o)
      else $error("operation dropped before last round");

   // R9
   start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i) |=> busy_o)
      else $error("idle start not accepted");

   // R9
   start_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |=> $stable(addr_q))
      else $error("start while busy reloaded the request");

   // R10
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (grant_o == '0 && bank_en_o == '0 && !done_o))
      else $error("outputs active while idle");

endmodule

// File: tb/smem_bank_arbiter_tb.sv
module smem_bank_arbiter_tb;
   localparam int TH = 16;
   localparam int NB = 16;
   localparam int AW = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start_i = 1'b0;
   logic [TH-1:0]     req_active_i = '0;
   logic [TH*AW-1:0]  req_addr_i = '0;
   logic              busy_o, done_o;
   logic [TH-1:0]     grant_o;
   logic [NB-1:0]     bank_en_o;
   logic [NB*AW-1:0]  bank_addr_o;

   smem_bank_arbiter #(.THREADS(TH), .BANKS(NB), .AW(AW)) u_dut (
      .clk, .rst_n, .start_i, .req_active_i, .req_addr_i,
      .busy_o, .done_o, .grant_o, .bank_en_o, .bank_addr_o
   );

   always #2.5ns clk = ~clk;

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;

   logic [TH-1:0] act_tb;
   logic [AW-1:0] adr[TH];

   task automatic chk(input bit ok, input string req, input string msg);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: %s", req, msg);
      end
   endtask

   function automatic int bank_of(input logic [AW-1:0] a);
      return int'(a) % NB;
   endfunction

   // R5: max distinct active addresses in one bank, at least 1
   function automatic int exp_rounds();
      int best = 1;
      for (int b = 0; b < NB; b++) begin
         int n = 0;
         for (int t = 0; t < TH; t++) begin
            bit first = act_tb[t] && bank_of(adr[t]) == b;
            for (int u = 0; u < t; u++)
               if (act_tb[u] && adr[u] == adr[t]) first = 1'b0;
            if (first) n++;
         end
         if (n > best) best = n;
      end
      return best;
   endfunction

   task automatic round_check(input logic [TH-1:0] pend, input string name);
      bit ok_sub = ((grant_o & ~pend) == '0);
      bit ok_adr = 1'b1;
      bit ok_low = 1'b1;
      bit ok_bc  = 1'b1;
      for (int t = 0; t < TH; t++) begin
         int b = bank_of(adr[t]);
         if (grant_o[t] && (!bank_en_o[b] || bank_addr_o[b*AW +: AW] != adr[t])) ok_adr = 1'b0;
      end
      for (int b = 0; b < NB; b++) begin
         int low = -1;
         for (int t = TH - 1; t >= 0; t--)
            if (pend[t] && bank_of(adr[t]) == b) low = t;
         if (low < 0) begin
            if (bank_en_o[b]) ok_low = 1'b0;
         end else if (!grant_o[low]) ok_low = 1'b0;
      end
      for (int t = 0; t < TH; t++)
         for (int u = 0; u < TH; u++)
            if (pend[t] && grant_o[u] && adr[u] == adr[t] && !grant_o[t]) ok_bc = 1'b0;
      chk(ok_sub, "R7", $sformatf("%s grant=%h pending=%h expected subset", name, grant_o, pend));
      chk(ok_adr, "R1", $sformatf("%s granted thread address not in its bank slot, grant=%h en=%h", name, grant_o, bank_en_o));
      chk(ok_low, "R3", $sformatf("%s lowest pending thread per bank not served, grant=%h pending=%h", name, grant_o, pend));
      chk(ok_bc, "R4", $sformatf("%s same-address thread left out, grant=%h", name, grant_o));
      chk(done_o == ((pend & ~grant_o) == '0), "R5",
          $sformatf("%s done=%0b expected %0b", name, done_o, ((pend & ~grant_o) == '0)));
   endtask

   task automatic run_op(input string name, input bit poke, output logic [TH-1:0] first_grant);
      int exp = exp_rounds();
      int rounds = 0;
      logic [TH-1:0] pend = act_tb;
      logic [TH-1:0] seen = '0;
      bit dup = 1'b0;
      first_grant = '0;
      @(negedge clk);
      req_active_i = act_tb;
      for (int t = 0; t < TH; t++) req_addr_i[t*AW +: AW] = adr[t];
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(busy_o == 1'b1, "R9", $sformatf("%s busy=%0b expected 1 after start", name, busy_o));
      while (busy_o && rounds < 40) begin
         rounds++;
         round_check(pend, name);
         if (rounds == 1) first_grant = grant_o;
         if ((seen & grant_o) != '0) dup = 1'b1;
         seen = seen | grant_o;
         pend = pend & ~grant_o;
         if (poke && rounds == 1) begin
            start_i = 1'b1;
            req_active_i = '1;
            req_addr_i = '0;
         end
         @(negedge clk);
         start_i = 1'b0;
      end
      chk(rounds == exp, poke ? "R9" : "R5",
          $sformatf("%s rounds=%0d expected %0d", name, rounds, exp));
      chk(seen == act_tb && !dup, "R6",
          $sformatf("%s granted=%h expected %h once each", name, seen, act_tb));
      chk(!busy_o && !done_o, "R5", $sformatf("%s busy=%0b after done expected 0", name, busy_o));
   endtask

   task automatic t_reset();
      chk(!busy_o && !done_o && grant_o == '0 && bank_en_o == '0, "R10",
          $sformatf("in reset busy=%0b done=%0b grant=%h en=%h expected zeros", busy_o, done_o, grant_o, bank_en_o));
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      chk(!busy_o && !done_o && grant_o == '0 && bank_en_o == '0, "R10",
          $sformatf("after reset busy=%0b done=%0b grant=%h en=%h expected zeros", busy_o, done_o, grant_o, bank_en_o));
   endtask

   task automatic t_distinct();
      logic [TH-1:0] g;
      act_tb = '1;
      for (int t = 0; t < TH; t++) adr[t] = AW'(t + 16 * (t % 3));
      run_op("distinct banks", 1'b0, g);
      chk(g == '1, "R1", $sformatf("distinct banks grant=%h expected ffff", g));
   endtask

   task automatic t_broadcast();
      logic [TH-1:0] g;
      act_tb = '1;
      for (int t = 0; t < TH; t++) adr[t] = 8'h5A;
      run_op("broadcast", 1'b0, g);
      chk(g == '1, "R4", $sformatf("broadcast grant=%h expected ffff", g));
   endtask

   task automatic t_worst();
      logic [TH-1:0] g;
      act_tb = '1;
      for (int t = 0; t < TH; t++) adr[t] = AW'(16 * t);
      run_op("one bank", 1'b0, g);
      chk(g == 16'h0001, "R3", $sformatf("one bank first grant=%h expected 0001", g));
   endtask

   task automatic t_mixed();
      logic [TH-1:0] g;
      act_tb = '1;
      for (int t = 0; t < TH; t++) adr[t] = AW'((t % 4) + 16 * (t / 8));
      run_op("mixed", 1'b0, g);
      chk(g == 16'h00FF, "R2", $sformatf("mixed first grant=%h expected 00ff", g));
   endtask

   task automatic t_inactive();
      logic [TH-1:0] g;
      act_tb = 16'h000F;
      for (int t = 0; t < TH; t++) adr[t] = (t < 4) ? AW'(t) : AW'(16 * t);
      run_op("inactive", 1'b0, g);
      chk(g == 16'h000F, "R7", $sformatf("inactive grant=%h expected 000f", g));
   endtask

   task automatic t_none();
      logic [TH-1:0] g;
      act_tb = '0;
      for (int t = 0; t < TH; t++) adr[t] = AW'(16 * t);
      run_op("none active", 1'b0, g);
      chk(g == '0, "R8", $sformatf("none active grant=%h expected 0000", g));
   endtask

   task automatic t_poke();
      logic [TH-1:0] g;
      act_tb = '1;
      for (int t = 0; t < TH; t++) adr[t] = AW'((t % 2) + 16 * ((t % 8) / 2));
      run_op("start while busy", 1'b1, g);
      chk(g == 16'h0303, "R9", $sformatf("poke first grant=%h expected 0303", g));
   endtask

   task automatic t_random();
      logic [TH-1:0] g;
      logic [15:0] lfsr = 16'hACE1;
      for (int n = 0; n < 6; n++) begin
         for (int t = 0; t < TH; t++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            adr[t] = AW'(lfsr & 16'h003F);
            act_tb[t] = lfsr[9] | lfsr[4];
         end
         run_op($sformatf("random %0d", n), 1'b0, g);
      end
   endtask

   initial begin
      t_reset();
      t_distinct();
      t_broadcast();
      t_worst();
      t_mixed();
      t_inactive();
      t_none();
      t_poke();
      t_random();
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not finish, actual hung expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule